// File: doc/BRIEF.md
# Bicolor Backlight Color Driver

This block drives a backlight built from anti-parallel bicolor LEDs through two active-high sink lines. Current in one direction lights the LEDs red and in the other direction green. No current leaves the backlight dark. A host register supplies a 2-bit color command. The block turns that command into the pair of line levels, and both lines are registered outputs.

Red, green and off are static line patterns. Yellow is made by the block itself: it alternates the red and green patterns at a fixed toggle rate, so the eye blends the two colors. The toggle period in clock cycles comes from two parameters, the clock frequency and the toggle frequency. A third parameter sets the red share of that period in sixteenths, which lets the hue be tuned.

The two lines are never high together. Whenever the polarity reverses, both lines are held low for one clock.

Top module: `bicolor_backlight_drv`

## Requirements
- R1: Output bit 0 is the red sink line and bit 1 is the green sink line. A command of 2'b01 (red) gives `drive_o` = 2'b01 from the first clock edge that samples it, unless the lines were showing green.
- R2: A command of 2'b10 (green) gives `drive_o` = 2'b10 from the first clock edge that samples it, unless the lines were showing red.
- R3: A command of 2'b00 (off) gives `drive_o` = 2'b00 at the first clock edge that samples it.
- R4: While `rst_n` is low at a clock edge, `drive_o` becomes 2'b00, whatever the command is.
- R5: `drive_o` is never 2'b11.
- R6: Every change between red (2'b01) and green (2'b10) passes through exactly one clock of 2'b00.
- R7: Command 2'b11 (yellow) alternates red and green with a period of P = CLK_HZ/TOGGLE_HZ clocks. The phase counter runs from 0 to P-1 and then wraps.
- R8: Within the yellow period, red is targeted while the phase counter is below floor(P*RED_SIXTEENTHS/16), and green is targeted for the rest of the period. The first clock of each color after a reversal is the 2'b00 gap.
- R9: Each time yellow is newly selected, the phase counter starts again at 0, so the red part begins at the first edge that samples the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| color_cmd | input | 2 | Color command: 00 off, 01 red, 10 green, 11 yellow |
| drive_o | output | 2 | Sink drive lines: bit 0 red direction, bit 1 green direction |

## Verification
The bench aims at the polarity reversals: direct red/green swaps, the two boundaries inside the yellow period, and entry into yellow while green is showing. A design without the gap would show green the clock right after red. A design that overlapped the two lines would show 2'b11. The bench follows the yellow waveform one cycle at a time over two periods with an uneven duty. An off-by-one in the divider or in the duty threshold moves the gap cycles away from where they are expected. The bench also leaves yellow in the middle of a period and selects it again. A counter that free-runs instead of restarting would begin that new yellow in the green part.

// File: rtl/backlight_pkg.sv
// Shared definitions for the bicolor backlight driver.
// Assumes bit 0 of a drive word sinks the red direction and bit 1 the green.
package backlight_pkg;

    typedef enum logic [1:0] {
        COL_OFF    = 2'b00,
        COL_RED    = 2'b01,
        COL_GREEN  = 2'b10,
        COL_YELLOW = 2'b11
    } color_e;

    localparam logic [1:0] DRV_DARK  = 2'b00;
    localparam logic [1:0] DRV_RED   = 2'b01;
    localparam logic [1:0] DRV_GREEN = 2'b10;

endpackage

// File: rtl/bl_phase_gen.sv
// Yellow phase generator: a modulo-PERIOD counter that runs only while
// yellow is selected and sits at zero otherwise. red_phase is high for the
// first RED_CYC counts of each period.
// Assumes PERIOD >= 2 and 0 < RED_CYC < PERIOD.
module bl_phase_gen #(
    parameter int PERIOD  = 320,
    parameter int RED_CYC = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic red_phase
);
    localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] SPLIT = CNT_W'(RED_CYC);

    logic [CNT_W-1:0] cnt_q;

    // Advance the phase while running, hold it at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Red part of the period comes first.
    always_comb begin
        red_phase = (cnt_q < SPLIT);
    end

    assert_phase_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    assert_phase_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/bl_color_map.sv
// Color mapper: picks the drive word the lines should head for, from the
// command and the current yellow phase. Purely combinational.
module bl_color_map
    import backlight_pkg::*;
(
    input  color_e     cmd,
    input  logic       red_phase,
    output logic [1:0] target
);
    // Translate the command into a target line pattern.
    always_comb begin
        case (cmd)
            COL_RED:    target = DRV_RED;
            COL_GREEN:  target = DRV_GREEN;
            COL_YELLOW: target = red_phase ? DRV_RED : DRV_GREEN;
            default:    target = DRV_DARK;
        endcase
    end

endmodule

// File: rtl/bl_drive_guard.sv
// Break-before-make output stage: registers the target pattern. When the
// target is the opposite polarity of what is showing, it drives both lines
// low for one clock first.
// Assumes target is never 2'b11.
module bl_drive_guard
    import backlight_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] target,
    output logic [1:0] drive_q
);
    logic reversing;

    // Reversal means both words are lit and they differ.
    always_comb begin
        reversing = (drive_q != DRV_DARK) && (target != DRV_DARK) && (target != drive_q);
    end

    // Register the lines, inserting the dark gap on reversal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_q <= DRV_DARK;
        end else if (reversing) begin
            drive_q <= DRV_DARK;
        end else begin
            drive_q <= target;
        end
    end

    assert_reset_dark_R4: assert property (@(posedge clk)
        !rst_n |=> (drive_q == DRV_DARK));

    assert_never_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
        drive_q != 2'b11);

    assert_gap_after_red_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_q == DRV_RED) |=> (drive_q != DRV_GREEN));

    assert_gap_after_green_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_q == DRV_GREEN) |=> (drive_q != DRV_RED));

endmodule

// File: rtl/bicolor_backlight_drv.sv
// Bicolor backlight driver top. It turns a 2-bit color command into the two
// sink line levels, and it generates yellow as a timed red/green alternation.
// Assumes CLK_HZ/TOGGLE_HZ >= 2 and 1 <= RED_SIXTEENTHS <= 15.
module bicolor_backlight_drv
    import backlight_pkg::*;
#(
    parameter int CLK_HZ         = 250_000_000,
    parameter int TOGGLE_HZ      = 550,
    parameter int RED_SIXTEENTHS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] color_cmd,
    output logic [1:0] drive_o
);
    localparam int PERIOD  = CLK_HZ / TOGGLE_HZ;
    localparam int RED_CYC = (PERIOD * RED_SIXTEENTHS) / 16;

    color_e     cmd;
    logic       red_phase;
    logic [1:0] target;

    // Interpret the raw command as a color.
    always_comb begin
        cmd = color_e'(color_cmd);
    end

    bl_phase_gen #(
        .PERIOD  (PERIOD),
        .RED_CYC (RED_CYC)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (cmd == COL_YELLOW),
        .red_phase (red_phase)
    );

    bl_color_map u_map (
        .cmd       (cmd),
        .red_phase (red_phase),
        .target    (target)
    );

    bl_drive_guard u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .target  (target),
        .drive_q (drive_o)
    );

    assert_off_prompt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (color_cmd == 2'b00) |=> (drive_o == 2'b00));

    assert_red_prompt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (color_cmd == 2'b01 && drive_o != 2'b10) |=> (drive_o == 2'b01));

    assert_green_prompt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (color_cmd == 2'b10 && drive_o != 2'b01) |=> (drive_o == 2'b10));

endmodule

// File: tb/test_bicolor_backlight_drv.sv
// Directed bench. It uses P = 176000/550 = 320 and a red share of 4/16,
// so the red part of each yellow period is 80 counts.
module test_bicolor_backlight_drv;

    localparam int P   = 320;
    localparam int RED = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] color_cmd = 2'b00;
    logic [1:0] drive_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bicolor_backlight_drv #(
        .CLK_HZ         (176_000),
        .TOGGLE_HZ      (550),
        .RED_SIXTEENTHS (4)
    ) i_bicolor_backlight_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .color_cmd (color_cmd),
        .drive_o   (drive_o)
    );

    task automatic check(input string req, input logic [1:0] exp);
        checks++;
        if (drive_o !== exp) begin
            fails++;
            $display("FAIL %s: drive_o=%b expected %b at %0t", req, drive_o, exp, $time);
        end
    endtask

    // Apply a command at a falling edge, then sample one rising edge later.
    task automatic apply(input logic [1:0] c);
        color_cmd = c;
        @(negedge clk);
    endtask

    // Expected yellow output k edges after entry, entered from dark or red.
    function automatic logic [1:0] yel_exp(input int k);
        int c = k % P;
        if (k == 0)        return 2'b01;
        else if (c == 0)   return 2'b00;
        else if (c < RED)  return 2'b01;
        else if (c == RED) return 2'b00;
        else               return 2'b10;
    endfunction

    function automatic string yel_tag(input int k);
        int c = k % P;
        if (k != 0 && (c == 0 || c == RED)) return "R6";
        else if (c < RED)                   return "R8";
        else                                return "R7";
    endfunction

    task automatic t_reset();
        color_cmd = 2'b01;
        repeat (3) @(negedge clk);
        check("R4", 2'b00);
        color_cmd = 2'b11;
        @(negedge clk);
        check("R4", 2'b00);
        color_cmd = 2'b00;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_solid();
        apply(2'b01); check("R1", 2'b01);
        apply(2'b00); check("R3", 2'b00);
        apply(2'b10); check("R2", 2'b10);
        apply(2'b00); check("R3", 2'b00);
        apply(2'b01); check("R1", 2'b01);
        @(negedge clk); check("R1", 2'b01);
    endtask

    task automatic t_reverse();
        apply(2'b10); check("R6", 2'b00);
        @(negedge clk); check("R2", 2'b10);
        apply(2'b01); check("R6", 2'b00);
        @(negedge clk); check("R1", 2'b01);
        apply(2'b00); check("R3", 2'b00);
    endtask

    task automatic t_yellow();
        int reds = 0;
        int boths = 0;
        apply(2'b11);
        for (int k = 0; k < 2 * P; k++) begin
            check(yel_tag(k), yel_exp(k));
            if (drive_o == 2'b11) boths++;
            if (k >= P && drive_o == 2'b01) reds++;
            @(negedge clk);
        end
        checks++;
        if (reds != RED - 1) begin
            fails++;
            $display("FAIL R8: red cycles in period=%0d expected %0d", reds, RED - 1);
        end
        checks++;
        if (boths != 0) begin
            fails++;
            $display("FAIL R5: cycles with both lines high=%0d expected 0", boths);
        end
    endtask

    task automatic t_restart();
        apply(2'b00);
        apply(2'b11);
        repeat (149) @(negedge clk);
        check("R7", 2'b10);
        apply(2'b01); check("R6", 2'b00);
        @(negedge clk); check("R1", 2'b01);
        apply(2'b11);
        for (int k = 0; k < RED + 4; k++) begin
            check("R9", yel_exp(k));
            @(negedge clk);
        end
        apply(2'b10);
        @(negedge clk); check("R2", 2'b10);
        apply(2'b11);
        for (int k = 0; k < RED + 4; k++) begin
            check("R9", (k == 0) ? 2'b00 : yel_exp(k));
            @(negedge clk);
        end
        apply(2'b00); check("R3", 2'b00);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_solid();
        t_reverse();
        t_yellow();
        t_restart();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100_000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule